// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Data Cache

This block records the cache misses that are still waiting on the next memory level, so the data cache can keep serving accesses while those misses are outstanding. Each miss arrives with a block address and a descriptor for the access: load or store, access size, byte position in the block, and a destination tag. A miss to a block that is already tracked is folded into that block's entry. A miss to a new block takes a free entry and causes one request to memory. When there is no room for the miss, the block raises a stall and does not accept it.

Returning data comes back one 16-byte subblock at a time, tagged with the entry index. In the cycle a subblock arrives, every load waiting on it receives its bytes and its waiting position is released. Store bytes that were buffered earlier take precedence over the returning bytes. A load to a tracked block whose subblock has already arrived is answered at once from the buffered data. When all four subblocks are present, the whole 64-byte block is offered to the cache write port. The entry is released after that write is acknowledged.

Top module: `miss_tracker`

## Requirements
- R1: After reset no entry is in use, and `missStall`, `memReqValid`, `wrValid`, `hitValid` and every `fwdValid` bit are 0.
- R2: A miss accepted with no matching entry takes the lowest-numbered free entry. From the next cycle `memReqValid` is 1 with that block and entry index. It stays 1 until a cycle with `memReqReady` high, and each entry is requested exactly once.
- R3: A miss to a block that already has an entry creates no new entry and no new memory request.
- R4: When no entry matches and all four entries are in use, `missStall` is 1 in that cycle and the miss has no effect.
- R5: A load or store that needs a waiting position (its subblock has not arrived) stalls when all four positions of the matching entry are taken.
- R6: In the cycle a subblock arrives for a non-arrived subblock of a valid entry, each load waiting on it has its `fwdValid` bit set, with its tag and data. Only loads are forwarded. Size code 0/1/2/3 means 1/2/4/8 bytes. Offset bits [5:4] select the subblock and bits [3:0] the byte. Data is little-endian and zero-extended to 64 bits.
- R7: Loads and stores waiting on an arriving subblock release their positions at that clock edge, so later misses can use them.
- R8: A load to a tracked block whose subblock has arrived gets `hitValid`=1 with its data in the same cycle. It takes no waiting position.
- R9: Store lane b (bits 8b+7:8b of `missStoreData`) is written to block byte offset+b for each of the bytes given by the size code. These bytes overrule later returning data. They show up in forwarded loads, in hits and in the written block.
- R10: Once all four subblocks are present, `wrValid` is 1 with the block address and all 512 bits of data, and stays 1 until `wrAck`. Misses to that block stall while it waits. After the acknowledge edge the entry is free.
- R11: A prefetch miss takes an entry and a memory request but no waiting position. A prefetch to a tracked block has no effect. `wrPrefetch` is 1 only if no demand miss merged into the entry.
- R12: A miss to the entry being filled in the same cycle stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss presented |
| missBlock | input | 26 | Block address of the miss |
| missIsStore | input | 1 | 1 for a store, 0 for a load |
| missPrefetch | input | 1 | Miss is a prefetch |
| missSize | input | 2 | Size code (1/2/4/8 bytes) |
| missOffset | input | 6 | Byte offset in the block |
| missTag | input | 6 | Destination tag |
| missStoreData | input | 64 | Store bytes, lane 0 first |
| missStall | output | 1 | Miss not accepted this cycle |
| hitValid | output | 1 | Load answered from buffered data |
| hitData | output | 64 | Data for that load |
| memReqValid | output | 1 | Request to next level pending |
| memReqBlock | output | 26 | Requested block |
| memReqEntry | output | 2 | Entry that will take the fill |
| memReqReady | input | 1 | Next level takes the request |
| fillValid | input | 1 | Subblock returning |
| fillEntry | input | 2 | Entry being filled |
| fillSub | input | 2 | Subblock index |
| fillData | input | 128 | Subblock bytes |
| fwdValid | output | 4 | Forward per waiting position |
| fwdTag | output | 24 | Tags, 6 bits per position |
| fwdData | output | 256 | Data, 64 bits per position |
| wrValid | output | 1 | Complete block ready for the cache |
| wrBlock | output | 26 | Its address |
| wrPrefetch | output | 1 | Block was fetched only by prefetch |
| wrData | output | 512 | Block bytes, byte 0 lowest |
| wrAck | input | 1 | Cache has written the block |

## Verification
Hit answers, forwards and stall are combinational, so they are due in the same cycle as the miss or fill that causes them. The bench drives inputs just after the falling edge and samples these outputs one nanosecond later, before the next rising edge. Entry state, memory requests and the write offer change at the rising edge, so the bench checks them at the following falling edge, one cycle after the stimulus. Expected forward, hit and block data come from a byte-level model in the bench. The model applies stores first and lets fill bytes fill only the bytes no store has written.

// File: rtl/miss_pkg.sv
package miss_pkg;
  parameter int NUM_ENT   = 4;
  parameter int NUM_SLOT  = 4;
  parameter int NUM_SUB   = 4;
  parameter int SUB_BYTES = 16;
  parameter int BLK_W     = 26;
  parameter int TAG_W     = 6;
  parameter int ST_W      = 64;

  localparam int ENT_W     = $clog2(NUM_ENT);
  localparam int SLOT_W    = $clog2(NUM_SLOT);
  localparam int SUB_W     = $clog2(NUM_SUB);
  localparam int SUB_BITS  = SUB_BYTES * 8;
  localparam int BLK_BYTES = NUM_SUB * SUB_BYTES;
  localparam int BLK_BITS  = BLK_BYTES * 8;
  localparam int OFF_W     = $clog2(BLK_BYTES);
  localparam int BYTE_W    = $clog2(SUB_BYTES);
  localparam int ST_BYTES  = ST_W / 8;

  typedef struct packed {
    logic             allocEn;
    logic [ENT_W-1:0] allocIdx;
    logic             storeEn;
    logic [ENT_W-1:0] storeIdx;
    logic             fillEn;
    logic [ENT_W-1:0] fillIdx;
  } strobe_t;

  function automatic logic [ST_W-1:0] pickBytes(input logic [SUB_BITS-1:0] sub,
                                                 input logic [BYTE_W-1:0] pos,
                                                 input logic [1:0] size);
    logic [ST_W-1:0] r;
    r = '0;
    for (int b = 0; b < ST_BYTES; b++)
      if (b < (1 << size)) r[8*b +: 8] = sub[8*((int'(pos) + b) % SUB_BYTES) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/miss_dpath.sv
module miss_dpath
  import miss_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [OFF_W-1:0]    stOff,
  input  logic [1:0]          stSize,
  input  logic [ST_W-1:0]     stData,
  input  logic [SUB_W-1:0]    fillSub,
  input  logic [SUB_BITS-1:0] fillData,
  input  logic [ENT_W-1:0]    readIdx,
  input  logic [SUB_W-1:0]    readSub,
  output logic [SUB_BITS-1:0] readSubData,
  output logic [SUB_BITS-1:0] fillMerged,
  input  logic [ENT_W-1:0]    wrIdx,
  output logic [BLK_BITS-1:0] wrData
);
  logic [BLK_BITS-1:0]  dat [NUM_ENT];
  logic [BLK_BYTES-1:0] msk [NUM_ENT];

  always_comb begin
    readSubData = dat[readIdx][int'(readSub)*SUB_BITS +: SUB_BITS];
    wrData      = dat[wrIdx];
    for (int j = 0; j < SUB_BYTES; j++)
      fillMerged[8*j +: 8] = msk[stb.fillIdx][int'(fillSub)*SUB_BYTES + j]
                           ? dat[stb.fillIdx][8*(int'(fillSub)*SUB_BYTES + j) +: 8]
                           : fillData[8*j +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENT; e++) msk[e] <= '0;
    end else begin
      if (stb.allocEn) msk[stb.allocIdx] <= '0;
      if (stb.fillEn) dat[stb.fillIdx][int'(fillSub)*SUB_BITS +: SUB_BITS] <= fillMerged;
      if (stb.storeEn) begin
        for (int b = 0; b < ST_BYTES; b++)
          if (b < (1 << stSize)) begin
            dat[stb.storeIdx][8*((int'(stOff) + b) % BLK_BYTES) +: 8] <= stData[8*b +: 8];
            msk[stb.storeIdx][(int'(stOff) + b) % BLK_BYTES]          <= 1'b1;
          end
      end
    end
  end

  // store bytes stay marked until the entry is reallocated
  AST_STORE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    stb.storeEn && !stb.allocEn |=> msk[$past(stb.storeIdx)][$past(int'(stOff))]) else $error("store mask"); // R9
endmodule

// File: rtl/miss_ctrl.sv
module miss_ctrl
  import miss_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      missValid,
  input  logic [BLK_W-1:0]          missBlock,
  input  logic                      missIsStore,
  input  logic                      missPrefetch,
  input  logic [1:0]                missSize,
  input  logic [OFF_W-1:0]          missOffset,
  input  logic [TAG_W-1:0]          missTag,
  output logic                      missStall,
  output logic                      hitValid,
  output logic [ST_W-1:0]           hitData,
  output logic                      memReqValid,
  output logic [BLK_W-1:0]          memReqBlock,
  output logic [ENT_W-1:0]          memReqEntry,
  input  logic                      memReqReady,
  input  logic                      fillValid,
  input  logic [ENT_W-1:0]          fillEntry,
  input  logic [SUB_W-1:0]          fillSub,
  output logic [NUM_SLOT-1:0]       fwdValid,
  output logic [NUM_SLOT*TAG_W-1:0] fwdTag,
  output logic [NUM_SLOT*ST_W-1:0]  fwdData,
  output logic                      wrValid,
  output logic [BLK_W-1:0]          wrBlock,
  output logic                      wrPrefetch,
  output logic [ENT_W-1:0]          wrIdx,
  input  logic                      wrAck,
  output strobe_t                   stb,
  output logic [ENT_W-1:0]          readIdx,
  output logic [SUB_W-1:0]          readSub,
  input  logic [SUB_BITS-1:0]       readSubData,
  input  logic [SUB_BITS-1:0]       fillMerged
);
  logic [NUM_ENT-1:0]  entV, entPf, entIss;
  logic [BLK_W-1:0]    entBlk [NUM_ENT];
  logic [NUM_SUB-1:0]  entArr [NUM_ENT];
  logic [NUM_SLOT-1:0] slV [NUM_ENT];
  logic [NUM_SLOT-1:0] slSt [NUM_ENT];
  logic [1:0]          slSz  [NUM_ENT][NUM_SLOT];
  logic [OFF_W-1:0]    slOff [NUM_ENT][NUM_SLOT];
  logic [TAG_W-1:0]    slTag [NUM_ENT][NUM_SLOT];

  logic matchAny, freeAny, slFreeAny, subArr, needSlot, fillHere, accept, newAlloc, takeSlot, dupBlk;
  logic [ENT_W-1:0]  matchIdx, freeIdx, entUse;
  logic [SLOT_W-1:0] slFreeIdx, slotUse;
  logic [SUB_W-1:0]  missSub;

  always_comb begin
    matchAny = 1'b0; matchIdx = '0; freeAny = 1'b0; freeIdx = '0;
    memReqValid = 1'b0; memReqEntry = '0; wrValid = 1'b0; wrIdx = '0; dupBlk = 1'b0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (entV[e] && entBlk[e] == missBlock) begin matchAny = 1'b1; matchIdx = ENT_W'(e); end
      if (!entV[e]) begin freeAny = 1'b1; freeIdx = ENT_W'(e); end
      if (entV[e] && !entIss[e]) begin memReqValid = 1'b1; memReqEntry = ENT_W'(e); end
      if (entV[e] && &entArr[e]) begin wrValid = 1'b1; wrIdx = ENT_W'(e); end
      for (int k = e + 1; k < NUM_ENT; k++)
        if (entV[e] && entV[k] && entBlk[e] == entBlk[k]) dupBlk = 1'b1;
    end
    slFreeAny = 1'b0; slFreeIdx = '0;
    for (int s = NUM_SLOT - 1; s >= 0; s--)
      if (!slV[matchIdx][s]) begin slFreeAny = 1'b1; slFreeIdx = SLOT_W'(s); end

    missSub  = missOffset[OFF_W-1 -: SUB_W];
    subArr   = matchAny && entArr[matchIdx][missSub];
    needSlot = !missPrefetch && !subArr;
    fillHere = fillValid && entV[fillEntry] && !entArr[fillEntry][fillSub];
    missStall = missValid && ((fillValid && matchAny && fillEntry == matchIdx)
                           || (matchAny && &entArr[matchIdx])
                           || (matchAny && needSlot && !slFreeAny)
                           || (!matchAny && !freeAny));
    accept   = missValid && !missStall;
    newAlloc = accept && !matchAny;
    takeSlot = accept && needSlot;
    entUse   = matchAny ? matchIdx : freeIdx;
    slotUse  = matchAny ? slFreeIdx : '0;

    hitValid = accept && subArr && !missIsStore && !missPrefetch;
    readIdx  = matchIdx;
    readSub  = missSub;
    hitData  = pickBytes(readSubData, missOffset[BYTE_W-1:0], missSize);

    memReqBlock = entBlk[memReqEntry];
    wrBlock     = entBlk[wrIdx];
    wrPrefetch  = entPf[wrIdx];

    stb.allocEn  = newAlloc;
    stb.allocIdx = freeIdx;
    stb.storeEn  = accept && missIsStore && !missPrefetch;
    stb.storeIdx = entUse;
    stb.fillEn   = fillHere;
    stb.fillIdx  = fillEntry;
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_fwd
    assign fwdValid[s] = fillHere && slV[fillEntry][s] && !slSt[fillEntry][s]
                      && slOff[fillEntry][s][OFF_W-1 -: SUB_W] == fillSub;
    assign fwdTag[s*TAG_W +: TAG_W] = slTag[fillEntry][s];
    assign fwdData[s*ST_W +: ST_W]  = pickBytes(fillMerged, slOff[fillEntry][s][BYTE_W-1:0],
                                                slSz[fillEntry][s]);

    AST_FWD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      fwdValid[s] |=> !slV[$past(fillEntry)][s]) else $error("slot kept"); // R7
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entV <= '0; entPf <= '0; entIss <= '0;
      for (int e = 0; e < NUM_ENT; e++) begin entArr[e] <= '0; slV[e] <= '0; end
    end else begin
      if (memReqValid && memReqReady) entIss[memReqEntry] <= 1'b1;
      if (fillHere) begin
        entArr[fillEntry][fillSub] <= 1'b1;
        for (int s = 0; s < NUM_SLOT; s++)
          if (slOff[fillEntry][s][OFF_W-1 -: SUB_W] == fillSub) slV[fillEntry][s] <= 1'b0;
      end
      if (wrValid && wrAck) entV[wrIdx] <= 1'b0;
      if (newAlloc) begin
        entV[freeIdx]   <= 1'b1;
        entBlk[freeIdx] <= missBlock;
        entPf[freeIdx]  <= missPrefetch;
        entIss[freeIdx] <= 1'b0;
        entArr[freeIdx] <= '0;
      end else if (accept && !missPrefetch) begin
        entPf[matchIdx] <= 1'b0;
      end
      if (takeSlot) begin
        slV[entUse][slotUse]   <= 1'b1;
        slSt[entUse][slotUse]  <= missIsStore;
        slSz[entUse][slotUse]  <= missSize;
        slOff[entUse][slotUse] <= missOffset;
        slTag[entUse][slotUse] <= missTag;
      end
    end
  end

  AST_ONE_ENTRY_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !dupBlk) else $error("duplicate block"); // R3
  AST_ALLOC_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    newAlloc |=> memReqValid) else $error("no request"); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memReqReady |=> memReqValid) else $error("request dropped"); // R2
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid && !wrAck |=> wrValid) else $error("write dropped"); // R10
  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    wrValid && wrAck |=> !entV[$past(wrIdx)]) else $error("entry kept"); // R10
  AST_HIT_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    hitValid |=> $countones(slV[$past(readIdx)]) == $past($countones(slV[readIdx])))
    else $error("hit took slot"); // R8
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import miss_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      missValid,
  input  logic [BLK_W-1:0]          missBlock,
  input  logic                      missIsStore,
  input  logic                      missPrefetch,
  input  logic [1:0]                missSize,
  input  logic [OFF_W-1:0]          missOffset,
  input  logic [TAG_W-1:0]          missTag,
  input  logic [ST_W-1:0]           missStoreData,
  output logic                      missStall,
  output logic                      hitValid,
  output logic [ST_W-1:0]           hitData,
  output logic                      memReqValid,
  output logic [BLK_W-1:0]          memReqBlock,
  output logic [ENT_W-1:0]          memReqEntry,
  input  logic                      memReqReady,
  input  logic                      fillValid,
  input  logic [ENT_W-1:0]          fillEntry,
  input  logic [SUB_W-1:0]          fillSub,
  input  logic [SUB_BITS-1:0]       fillData,
  output logic [NUM_SLOT-1:0]       fwdValid,
  output logic [NUM_SLOT*TAG_W-1:0] fwdTag,
  output logic [NUM_SLOT*ST_W-1:0]  fwdData,
  output logic                      wrValid,
  output logic [BLK_W-1:0]          wrBlock,
  output logic                      wrPrefetch,
  output logic [BLK_BITS-1:0]       wrData,
  input  logic                      wrAck
);
  strobe_t             stb;
  logic [ENT_W-1:0]    readIdx, wrIdx;
  logic [SUB_W-1:0]    readSub;
  logic [SUB_BITS-1:0] readSubData, fillMerged;

  miss_ctrl u_ctrl (
    .clk, .rst_n, .missValid, .missBlock, .missIsStore, .missPrefetch, .missSize,
    .missOffset, .missTag, .missStall, .hitValid, .hitData, .memReqValid, .memReqBlock,
    .memReqEntry, .memReqReady, .fillValid, .fillEntry, .fillSub, .fwdValid, .fwdTag,
    .fwdData, .wrValid, .wrBlock, .wrPrefetch, .wrIdx, .wrAck, .stb, .readIdx, .readSub,
    .readSubData, .fillMerged
  );

  miss_dpath u_dpath (
    .clk, .rst_n, .stb, .stOff(missOffset), .stSize(missSize), .stData(missStoreData),
    .fillSub, .fillData, .readIdx, .readSub, .readSubData, .fillMerged, .wrIdx, .wrData
  );
endmodule

// File: tb/miss_tracker_tb.sv
module miss_tracker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic missValid, missIsStore, missPrefetch, memReqReady, fillValid, wrAck;
  logic [25:0] missBlock; logic [1:0] missSize; logic [5:0] missOffset, missTag;
  logic [63:0] missStoreData; logic [1:0] fillEntry, fillSub; logic [127:0] fillData;
  logic missStall, hitValid, memReqValid, wrValid, wrPrefetch;
  logic [63:0] hitData; logic [25:0] memReqBlock, wrBlock; logic [1:0] memReqEntry;
  logic [3:0] fwdValid; logic [23:0] fwdTag; logic [255:0] fwdData; logic [511:0] wrData;

  miss_tracker u_dut (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0;
  logic [511:0] mdl; logic [63:0] mmsk;

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ext(input logic [511:0] blk, input int off, input int size);
    logic [63:0] r = '0;
    for (int b = 0; b < (1 << size); b++) r[8*b +: 8] = blk[8*((off + b) % 64) +: 8];
    return r;
  endfunction

  task automatic mReset(); mdl = '0; mmsk = '0; endtask
  task automatic mStore(input int off, input int size, input logic [63:0] d);
    for (int b = 0; b < (1 << size); b++) begin
      mdl[8*(off + b) +: 8] = d[8*b +: 8]; mmsk[off + b] = 1'b1;
    end
  endtask
  task automatic mFill(input int sub, input logic [127:0] d);
    for (int j = 0; j < 16; j++)
      if (!mmsk[sub*16 + j]) mdl[8*(sub*16 + j) +: 8] = d[8*j +: 8];
  endtask

  task automatic chkFwd(input string req, input int tag, input logic [63:0] exp);
    logic found = 1'b0; logic [63:0] got = '0;
    for (int s = 0; s < 4; s++)
      if (fwdValid[s] && fwdTag[6*s +: 6] == 6'(tag)) begin found = 1'b1; got = fwdData[64*s +: 64]; end
    check(req, {found, got}, {1'b1, exp});
  endtask

  task automatic idle();
    missValid = 0; missIsStore = 0; missPrefetch = 0; missSize = 0; missOffset = 0;
    missTag = 0; missStoreData = 0; fillValid = 0; fillEntry = 0; fillSub = 0; fillData = 0;
    missBlock = 0;
  endtask
  task automatic nxt(); @(negedge clk); idle(); endtask

  task automatic doMiss(input logic [25:0] blk, input logic st, input logic pf, input int size,
                        input int off, input int tag, input logic [63:0] sd);
    missValid = 1; missBlock = blk; missIsStore = st; missPrefetch = pf;
    missSize = 2'(size); missOffset = 6'(off); missTag = 6'(tag); missStoreData = sd;
  endtask

  task automatic doFill(input int ent, input int sub, input logic [127:0] d);
    fillValid = 1; fillEntry = 2'(ent); fillSub = 2'(sub); fillData = d;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    $display("FAIL watchdog expired");
    nChecks++; nFail++;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [25:0] blkA, blkB, blkC, blkD, blkE;
    logic [63:0] sd;
    logic [127:0] fd;
    idle(); memReqReady = 0; wrAck = 0;
    void'($urandom(32'h5eed));
    blkA = 26'($urandom()); blkB = blkA + 1; blkC = blkA + 2; blkD = blkA + 3; blkE = blkA + 4;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check("R1 reset outputs", {missStall, memReqValid, wrValid, hitValid, fwdValid}, '0);

    // R2 allocation and request handshake
    nxt(); doMiss(blkA, 0, 0, 2, 'h14, 1, 0); #1; mReset();
    check("R2 first miss accepted", missStall, 0);
    nxt(); #1;
    check("R2 request raised", {memReqValid, memReqBlock, memReqEntry}, {1'b1, blkA, 2'd0});
    nxt(); #1;
    check("R2 request held", memReqValid, 1); memReqReady = 1;
    nxt(); #1;
    check("R2 request issued once", memReqValid, 0);

    // R3 merge, R5 slot exhaustion
    nxt(); doMiss(blkA, 0, 0, 3, 'h20, 2, 0); #1;
    check("R3 merge accepted", missStall, 0);
    nxt(); #1;
    check("R3 no new request", memReqValid, 0);
    sd = {$urandom(), $urandom()};
    doMiss(blkA, 1, 0, 2, 'h18, 0, sd); #1; mStore('h18, 2, sd);
    check("R3 store merge accepted", missStall, 0);
    nxt(); doMiss(blkA, 0, 0, 3, 'h18, 3, 0); #1;
    check("R3 fourth slot accepted", missStall, 0);
    nxt(); doMiss(blkA, 0, 0, 0, 'h30, 7, 0); #1;
    check("R5 stall on full slots", missStall, 1);

    // R12 + R6 + R9: fill sub1 with a miss to the same entry
    nxt(); fd = rnd128(); doFill(0, 1, fd); doMiss(blkA, 0, 0, 0, 'h30, 7, 0); #1; mFill(1, fd);
    check("R12 stall during fill", missStall, 1);
    chkFwd("R6 forward tag1", 1, ext(mdl, 'h14, 2));
    chkFwd("R9 forward merged store bytes", 3, ext(mdl, 'h18, 3));
    check("R6 only loads forwarded", $countones(fwdValid), 2);

    // R7 released slots reusable
    nxt(); doMiss(blkA, 0, 0, 3, 'h38, 4, 0); #1; check("R7 slot reuse a", missStall, 0);
    nxt(); doMiss(blkA, 0, 0, 2, 'h34, 5, 0); #1; check("R7 slot reuse b", missStall, 0);
    nxt(); doMiss(blkA, 0, 0, 0, 'h30, 6, 0); #1; check("R7 slot reuse c", missStall, 0);

    // R8 hit on arrived subblock with full slots
    nxt(); doMiss(blkA, 0, 0, 1, 'h1C, 9, 0); #1;
    check("R8 hit answered", {missStall, hitValid, hitData}, {1'b0, 1'b1, ext(mdl, 'h1C, 1)});
    nxt(); sd = {$urandom(), $urandom()}; doMiss(blkA, 1, 0, 0, 'h10, 0, sd); #1; mStore('h10, 0, sd);
    check("R9 store to arrived sub needs no slot", missStall, 0);
    nxt(); doMiss(blkA, 0, 0, 3, 'h10, 10, 0); #1;
    check("R9 hit sees store byte", {hitValid, hitData}, {1'b1, ext(mdl, 'h10, 3)});

    nxt(); fd = rnd128(); doFill(0, 0, fd); #1; mFill(0, fd);
    nxt(); fd = rnd128(); doFill(0, 2, fd); #1; mFill(2, fd);
    chkFwd("R6 forward tag2", 2, ext(mdl, 'h20, 3));
    nxt(); fd = rnd128(); doFill(0, 3, fd); #1; mFill(3, fd);
    chkFwd("R6 forward tag4", 4, ext(mdl, 'h38, 3));
    chkFwd("R6 forward tag5", 5, ext(mdl, 'h34, 2));
    chkFwd("R6 forward tag6", 6, ext(mdl, 'h30, 0));

    // R10 write offer and release
    nxt(); doMiss(blkA, 0, 0, 0, 0, 11, 0); #1;
    check("R10 write offered", {wrValid, wrBlock, wrPrefetch}, {1'b1, blkA, 1'b0});
    check("R10 block data", wrData, mdl);
    check("R10 stall while awaiting write", missStall, 1);
    nxt(); #1; check("R10 write held", wrValid, 1); wrAck = 1;
    nxt(); wrAck = 0; #1; check("R10 entry released", wrValid, 0);
    doMiss(blkA, 0, 0, 0, 0, 11, 0); #1; check("R10 reallocation accepted", missStall, 0);
    nxt(); #1; check("R10 freed entry reused", {memReqValid, memReqEntry}, {1'b1, 2'd0});

    // R11 prefetch, R4 full table
    nxt(); doMiss(blkB, 0, 1, 0, 0, 0, 0); #1; check("R11 prefetch accepted", missStall, 0);
    nxt(); doMiss(blkC, 0, 1, 0, 0, 0, 0); #1;
    nxt(); doMiss(blkD, 0, 0, 0, 0, 12, 0); #1;
    nxt(); doMiss(blkB, 0, 1, 0, 0, 0, 0); #1; check("R11 repeat prefetch accepted", missStall, 0);
    nxt(); #1; check("R11 repeat prefetch no request", memReqValid, 0);
    doMiss(blkE, 0, 0, 0, 0, 14, 0); #1; check("R4 stall with table full", missStall, 1);
    nxt(); #1; check("R4 stalled miss no request", memReqValid, 0);
    doMiss(blkB, 0, 0, 3, 'h08, 13, 0); #1; check("R11 demand merges into prefetch", missStall, 0);

    mReset();
    for (int s = 0; s < 4; s++) begin nxt(); fd = rnd128(); doFill(2, s, fd); mFill(s, fd); end
    nxt(); #1;
    check("R11 prefetch-only block", {wrValid, wrBlock, wrPrefetch}, {1'b1, blkC, 1'b1});
    check("R10 prefetch block data", wrData, mdl);
    wrAck = 1; nxt(); wrAck = 0;
    mReset();
    for (int s = 0; s < 4; s++) begin
      nxt(); fd = rnd128(); doFill(1, s, fd); #1; mFill(s, fd);
      if (s == 0) chkFwd("R6 forward tag13", 13, ext(mdl, 'h08, 3));
    end
    nxt(); #1;
    check("R11 demand-merged block", {wrValid, wrBlock, wrPrefetch}, {1'b1, blkB, 1'b0});
    wrAck = 1; nxt(); wrAck = 0;

    // random hits and stores on entry 3 after subblock 0 arrives
    mReset();
    nxt(); fd = rnd128(); doFill(3, 0, fd); #1; mFill(0, fd);
    chkFwd("R6 forward tag12", 12, ext(mdl, 0, 0));
    for (int i = 0; i < 40; i++) begin
      int size, off;
      nxt();
      size = int'($urandom() % 4);
      off  = int'($urandom() % 16) & ~((1 << size) - 1);
      if ($urandom() % 3 == 0) begin
        sd = {$urandom(), $urandom()};
        doMiss(blkD, 1, 0, size, off, 0, sd); #1; mStore(off, size, sd);
        check("R9 random store accepted", {missStall, hitValid}, 2'b00);
      end else begin
        doMiss(blkD, 0, 0, size, off, 20, 0); #1;
        check("R8 random hit", {hitValid, hitData}, {1'b1, ext(mdl, off, size)});
      end
    end
    nxt(); #2;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule